// File: doc/BRIEF.md
# Module Clock Stop Controller

This block holds the clock-stop state of up to 384 peripheral modules. The modules are split into 12 groups of 32. Software reaches the block through a small register port. For every group there are three writable control views: a system view, a realtime view and a modem view. A module's clock runs only while its bit is clear in all three views. The block drives one enable output per module straight from the combined stop state.

Each group also has a read-only status word. It reports each module as running or stopped, but only after a fixed acknowledge latency. Software therefore enables a module in two steps. It first clears the bit with a read-modify-write of a control word. It then polls the status word until that bit reads 0.

Register access uses one address, a write strobe, a read strobe and a data word. A read returns its data on the clock after the strobe. Addresses that match no register are inert.

Top module: `mcs_ctrl`

## Requirements
- R1: After reset, every control word of every view reads 0xFFFFFFFF, every status word reads 0xFFFFFFFF, and every bit of `clk_en` is 0.
- R2: Module number n belongs to group n/32 at bit n%32 of that group's words, and its enable is `clk_en[n]`.
- R3: `clk_en[n]` is 1 exactly when bit n%32 is 0 in the system, realtime and modem words of group n/32. The output changes in the cycle after the write edge.
- R4: The system control word of group g (g = 0..11, in this order) sits at byte address 0x130, 0x134, 0x138, 0x13C, 0x140, 0x144, 0x148, 0x14C, 0x990, 0x994, 0x998, 0x99C. The realtime word sits 0x20 lower and the modem word 0x20 higher. All 32 bits of every control word are written and read back unchanged.
- R5: The status word of group g (g = 0..11, in this order) sits at 0x030, 0x038, 0x040, 0x048, 0x04C, 0x03C, 0x1C0, 0x1C4, 0x9A0, 0x9A4, 0x9A8, 0x9AC. A status bit reads 1 for a stopped module and 0 for a running one.
- R6: A status bit takes on a new stop state ACK_LAT clock edges after that state changes (default 4). With the write at edge E, a read strobe captured at edge E+ACK_LAT still returns the old bit, and one captured at edge E+ACK_LAT+1 returns the new bit.
- R7: Writes to a status address change neither any status word nor any control word nor `clk_en`.
- R8: A write to an address that matches no register has no effect. This includes addresses that are not word aligned. A read of such an address returns 0.
- R9: `rdata` is loaded only at a clock edge where `rd_en` is high, and it holds its value at every other edge.
- R10: When a write and a read to the same control word fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 12 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| clk_en | output | 384 | Per-module clock enable, 1 = clock running |

## Verification
A control bit that is corrupted inside a group shows up on `clk_en` in the very next cycle. It also shows up on readback of that view at the next read strobe. Faults in the acknowledge pipeline show up only in the status word. The bench therefore samples status at both sides of the latency boundary. A stage too few or too many moves the first read that shows the new bit by one strobe. A decoder that mixes up groups or views leaves the wrong enable set, or returns another word's contents, on the first access that uses the affected address.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam int MCS_MAX_GROUPS = 12;
  localparam int MCS_AW = 12;

  // distance from a system word to its realtime (below) and modem (above) views
  localparam logic [MCS_AW-1:0] VIEW_STRIDE = 12'h020;

  function automatic logic [MCS_AW-1:0] sys_base(input int g);
    case (g)
      0:  sys_base = 12'h130;
      1:  sys_base = 12'h134;
      2:  sys_base = 12'h138;
      3:  sys_base = 12'h13C;
      4:  sys_base = 12'h140;
      5:  sys_base = 12'h144;
      6:  sys_base = 12'h148;
      7:  sys_base = 12'h14C;
      8:  sys_base = 12'h990;
      9:  sys_base = 12'h994;
      10: sys_base = 12'h998;
      11: sys_base = 12'h99C;
      default: sys_base = '0;
    endcase
  endfunction

  function automatic logic [MCS_AW-1:0] stat_base(input int g);
    case (g)
      0:  stat_base = 12'h030;
      1:  stat_base = 12'h038;
      2:  stat_base = 12'h040;
      3:  stat_base = 12'h048;
      4:  stat_base = 12'h04C;
      5:  stat_base = 12'h03C;
      6:  stat_base = 12'h1C0;
      7:  stat_base = 12'h1C4;
      8:  stat_base = 12'h9A0;
      9:  stat_base = 12'h9A4;
      10: stat_base = 12'h9A8;
      11: stat_base = 12'h9AC;
      default: stat_base = '0;
    endcase
  endfunction

endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
#(
  parameter int NUM_GROUPS = 12
) (
  input  logic [MCS_AW-1:0]     addr,
  output logic [NUM_GROUPS-1:0] sel_sys,
  output logic [NUM_GROUPS-1:0] sel_rt,
  output logic [NUM_GROUPS-1:0] sel_mdm,
  output logic [NUM_GROUPS-1:0] sel_stat,
  output logic                  hit
);

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      sel_sys[g]  = (addr == sys_base(g));
      sel_rt[g]   = (addr == (sys_base(g) - VIEW_STRIDE));
      sel_mdm[g]  = (addr == (sys_base(g) + VIEW_STRIDE));
      sel_stat[g] = (addr == stat_base(g));
    end
    hit = |{sel_sys, sel_rt, sel_mdm, sel_stat};
  end

  always_comb begin
    // R4
    map_excl_chk: assert ($onehot0({sel_sys, sel_rt, sel_mdm, sel_stat}))
      else $error("address decodes to more than one register");
  end

endmodule

// File: rtl/mcs_ack_pipe.sv
module mcs_ack_pipe #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stop_i,
  output logic [W-1:0] stat_o
);

  localparam int CW = $clog2(DEPTH + 1);

  generate
    if (DEPTH < 1) begin : g_bad_depth
      $error("acknowledge latency must be at least one cycle");
    end
  endgenerate

  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = stop_i;
    for (int k = 1; k < DEPTH; k++) begin
      stg_d[k] = stg_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        stg_q[k] <= '1;
      end
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        stg_q[k] <= stg_d[k];
      end
    end
  end

  assign stat_o = stg_q[DEPTH-1];

  // latency watch: counts edges since the stop vector last changed
  logic [W-1:0]  stop_prev_q;
  logic [CW-1:0] quiet_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_prev_q <= '1;
      quiet_q     <= CW'(DEPTH);
    end else begin
      stop_prev_q <= stop_i;
      if (stop_i != stop_prev_q) begin
        quiet_q <= CW'(1);
      end else if (quiet_q != CW'(DEPTH)) begin
        quiet_q <= quiet_q + CW'(1);
      end
    end
  end

  // R6
  ack_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet_q == CW'(DEPTH)) |-> (stat_o == stop_prev_q));

endmodule

// File: rtl/mcs_group.sv
module mcs_group #(
  parameter int W       = 32,
  parameter int ACK_LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_sys,
  input  logic         wr_rt,
  input  logic         wr_mdm,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sys_q,
  output logic [W-1:0] rt_q,
  output logic [W-1:0] mdm_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] clk_en
);

  logic [W-1:0] sys_d, rt_d, mdm_d;
  logic [W-1:0] stop_vec;

  always_comb begin
    sys_d = wr_sys ? wdata : sys_q;
    rt_d  = wr_rt  ? wdata : rt_q;
    mdm_d = wr_mdm ? wdata : mdm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q <= '1;
      rt_q  <= '1;
      mdm_q <= '1;
    end else begin
      sys_q <= sys_d;
      rt_q  <= rt_d;
      mdm_q <= mdm_d;
    end
  end

  assign stop_vec = sys_q | rt_q | mdm_q;
  assign clk_en   = ~stop_vec;

  mcs_ack_pipe #(
    .W     (W),
    .DEPTH (ACK_LAT)
  ) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .stop_i (stop_vec),
    .stat_o (stat_q)
  );

  // R3
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sys || wr_rt || wr_mdm) |=> ((clk_en & $past(wdata)) == '0));

endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
  import mcs_pkg::*;
#(
  parameter int NUM_GROUPS = 12,
  parameter int GROUP_W    = 32,
  parameter int ACK_LAT    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [MCS_AW-1:0]             addr,
  input  logic [GROUP_W-1:0]            wdata,
  output logic [GROUP_W-1:0]            rdata,
  output logic [NUM_GROUPS*GROUP_W-1:0] clk_en
);

  localparam int NUM_MODS = NUM_GROUPS * GROUP_W;

  generate
    if (NUM_GROUPS > MCS_MAX_GROUPS) begin : g_bad_groups
      $error("register map holds at most %0d groups", MCS_MAX_GROUPS);
    end
  endgenerate

  logic [NUM_GROUPS-1:0] sel_sys, sel_rt, sel_mdm, sel_stat;
  logic                  map_hit;

  mcs_decode #(
    .NUM_GROUPS (NUM_GROUPS)
  ) u_dec (
    .addr     (addr),
    .sel_sys  (sel_sys),
    .sel_rt   (sel_rt),
    .sel_mdm  (sel_mdm),
    .sel_stat (sel_stat),
    .hit      (map_hit)
  );

  logic [NUM_GROUPS-1:0][GROUP_W-1:0] sys_all, rt_all, mdm_all, stat_all;

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      mcs_group #(
        .W       (GROUP_W),
        .ACK_LAT (ACK_LAT)
      ) u_grp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_sys (wr_en & sel_sys[g]),
        .wr_rt  (wr_en & sel_rt[g]),
        .wr_mdm (wr_en & sel_mdm[g]),
        .wdata  (wdata),
        .sys_q  (sys_all[g]),
        .rt_q   (rt_all[g]),
        .mdm_q  (mdm_all[g]),
        .stat_q (stat_all[g]),
        .clk_en (clk_en[g*GROUP_W +: GROUP_W])
      );
    end
  endgenerate

  // read path: one-hot select, registered on the read strobe
  logic [GROUP_W-1:0] rd_mux, rdata_d, rdata_q;

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (sel_sys[g])  rd_mux = rd_mux | sys_all[g];
      if (sel_rt[g])   rd_mux = rd_mux | rt_all[g];
      if (sel_mdm[g])  rd_mux = rd_mux | mdm_all[g];
      if (sel_stat[g]) rd_mux = rd_mux | stat_all[g];
    end
    rdata_d = rd_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  // R7
  stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (|sel_stat)) |=>
      ($stable(sys_all) && $stable(rt_all) && $stable(mdm_all)));

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !map_hit) |=>
      ($stable(sys_all) && $stable(rt_all) && $stable(mdm_all) && $stable(clk_en)));

  // R8
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !map_hit) |=> (rdata == '0));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: tb/tb_mcs_ctrl.sv
module tb_mcs_ctrl;

  localparam int G   = 12;
  localparam int W   = 32;
  localparam int LAT = 4;
  localparam int N   = G * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [11:0]   addr;
  logic [W-1:0]  wdata;
  logic [W-1:0]  rdata;
  logic [N-1:0]  clk_en;

  always #5 clk = ~clk;

  mcs_ctrl #(
    .NUM_GROUPS (G),
    .GROUP_W    (W),
    .ACK_LAT    (LAT)
  ) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .clk_en (clk_en)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [W-1:0] m_sys [G];
  logic [W-1:0] m_rt  [G];
  logic [W-1:0] m_mdm [G];

  function automatic logic [11:0] a_sys(input int g);
    logic [11:0] t [12] = '{12'h130, 12'h134, 12'h138, 12'h13C, 12'h140, 12'h144,
                            12'h148, 12'h14C, 12'h990, 12'h994, 12'h998, 12'h99C};
    return t[g];
  endfunction

  function automatic logic [11:0] a_stat(input int g);
    logic [11:0] t [12] = '{12'h030, 12'h038, 12'h040, 12'h048, 12'h04C, 12'h03C,
                            12'h1C0, 12'h1C4, 12'h9A0, 12'h9A4, 12'h9A8, 12'h9AC};
    return t[g];
  endfunction

  function automatic logic [11:0] a_view(input int kind, input int g);
    if (kind == 1) return a_sys(g) - 12'h020;
    if (kind == 2) return a_sys(g) + 12'h020;
    return a_sys(g);
  endfunction

  function automatic logic [N-1:0] exp_en();
    logic [N-1:0] r;
    for (int g = 0; g < G; g++) r[g*W +: W] = ~(m_sys[g] | m_rt[g] | m_mdm[g]);
    return r;
  endfunction

  task automatic chk32(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_en(input string tag);
    n_chk++;
    if (clk_en !== exp_en()) begin
      n_bad++;
      $display("FAIL %s: clk_en got %h expected %h", tag, clk_en, exp_en());
    end
  endtask

  // tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_view(input int kind, input int g, input logic [W-1:0] d);
    wr(a_view(kind, g), d);
    if (kind == 0) m_sys[g] = d;
    else if (kind == 1) m_rt[g] = d;
    else m_mdm[g] = d;
  endtask

  task automatic rd(input logic [11:0] a, output logic [W-1:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk_en("R1 enables after reset");
    for (int i = 0; i < 3; i++) begin
      int g = (i == 0) ? 0 : ((i == 1) ? 5 : 11);
      for (int k = 0; k < 3; k++) begin
        rd(a_view(k, g), v);
        chk32("R1 control word after reset", v, '1);
      end
      rd(a_stat(g), v);
      chk32("R1 status word after reset", v, '1);
    end
  endtask

  task automatic t_map();
    int n = 3 * 32 + 5;
    for (int k = 0; k < 3; k++) wr_view(k, 3, ~(32'h1 << 5));
    n_chk++;
    if (clk_en[n] !== 1'b1 || $countones(clk_en) != 1) begin
      n_bad++;
      $display("FAIL R2 module %0d enable: got %h expected only bit %0d", n, clk_en, n);
    end
    wr_view(1, 3, '1);
    n_chk++;
    if (clk_en[n] !== 1'b0) begin
      n_bad++;
      $display("FAIL R3 realtime view stop: got %b expected 0", clk_en[n]);
    end
    chk_en("R3 enables after realtime stop");
  endtask

  task automatic t_readback();
    logic [W-1:0] v;
    for (int g = 0; g < G; g++)
      for (int k = 0; k < 3; k++)
        wr_view(k, g, {8'(g * 17 + k), 8'h3C ^ 8'(k), 8'(~g), 8'(8'h90 >> k)});
    chk_en("R3 enables after pattern load");
    for (int g = 0; g < G; g++)
      for (int k = 0; k < 3; k++) begin
        rd(a_view(k, g), v);
        chk32("R4 readback", v, (k == 0) ? m_sys[g] : ((k == 1) ? m_rt[g] : m_mdm[g]));
      end
    for (int g = 0; g < G; g++)
      for (int k = 0; k < 3; k++) wr_view(k, g, '1);
    chk_en("R3 enables after restore");
    idle(LAT + 2);
  endtask

  task automatic t_status();
    logic [W-1:0] v;
    wr_view(0, 8, 32'hFFFF_FFFE);
    wr_view(1, 8, 32'hFFFF_FFFE);
    idle(LAT + 2);
    wr_view(2, 8, 32'hFFFF_FFFE);
    chk_en("R3 module 256 running");
    for (int k = 1; k <= LAT + 1; k++) begin
      rd(a_stat(8), v);
      chk32("R6 status on run", {31'b0, v[0]}, (k <= LAT) ? 32'd1 : 32'd0);
    end
    chk32("R5 status word running", v, 32'hFFFF_FFFE);
    wr_view(0, 8, '1);
    for (int k = 1; k <= LAT + 1; k++) begin
      rd(a_stat(8), v);
      chk32("R6 status on stop", {31'b0, v[0]}, (k <= LAT) ? 32'd0 : 32'd1);
    end
    chk32("R5 status word stopped", v, '1);
  endtask

  task automatic t_stat_ro();
    logic [W-1:0] v;
    wr(a_stat(2), '0);
    idle(LAT + 2);
    rd(a_stat(2), v);
    chk32("R7 status after write", v, '1);
    rd(a_sys(2), v);
    chk32("R7 control after status write", v, m_sys[2]);
    chk_en("R7 enables after status write");
  endtask

  task automatic t_unmapped();
    logic [W-1:0] v;
    wr(12'h000, '0);
    wr(12'h132, '0);
    wr(12'h9C0, '0);
    wr(12'hFFC, '0);
    chk_en("R8 enables after unmapped writes");
    rd(a_sys(0), v);
    chk32("R8 control after unmapped writes", v, '1);
    rd(12'h132, v);
    chk32("R8 unaligned read", v, '0);
    rd(12'h9C0, v);
    chk32("R8 unmapped read", v, '0);
  endtask

  task automatic t_hold();
    logic [W-1:0] v;
    wr_view(0, 1, 32'h1234_5678);
    rd(a_sys(1), v);
    chk32("R9 read before hold", v, 32'h1234_5678);
    addr = a_sys(4);
    idle(1);
    chk32("R9 hold with address change", rdata, 32'h1234_5678);
    wr_view(1, 1, 32'h0F0F_0F0F);
    chk32("R9 hold across write", rdata, 32'h1234_5678);
    chk_en("R3 enables after group 1 writes");
    addr = a_sys(1); wdata = 32'hCAFE_F00D; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    m_sys[1] = 32'hCAFE_F00D;
    chk32("R10 same-cycle read returns old", rdata, 32'h1234_5678);
    rd(a_sys(1), v);
    chk32("R10 later read returns new", v, 32'hCAFE_F00D);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    for (int g = 0; g < G; g++) begin
      m_sys[g] = '1; m_rt[g] = '1; m_mdm[g] = '1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_readback();
    t_status();
    t_stat_ro();
    t_unmapped();
    t_hold();
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    report();
    $finish;
  end

endmodule